// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block takes the 32-bit encoding of a single word or byte load/store instruction, together with the current base and index register values, and works out two things at once: the address the memory access should use and the value the base register should hold afterwards. The offset comes either from a 12-bit unsigned constant in the instruction or from the index register passed through a shifter whose amount is a constant in the instruction. The offset is then added to or subtracted from the base, and the instruction decides whether the access uses the adjusted or the original base, and whether the adjusted base is kept.

The block is purely combinational and is meant to sit between operand fetch and the data memory port of a pipeline. When the base register is the program counter, the block substitutes the instruction address plus the pipeline read-ahead and never asks for that register to be overwritten. The access size and direction bits are passed on untouched so that the memory stage can use them.

Top module: `ldst_addr_gen`

## Requirements
- R1: When instruction bit 25 is 0, the offset is instruction bits 11:0 zero-extended to the data width.
- R2: When bit 25 is 1, the offset is the index value shifted by the amount in bits 11:7, with the kind in bits 6:5 (00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right); bit 4 is not consulted and the amount never comes from a register.
- R3: A logical right shift with amount 0 gives an offset of 0, and an arithmetic right shift with amount 0 fills every bit with the sign bit of the index value (both behave as a shift by 32).
- R4: A rotate with amount 0 gives the carry input in the top bit and the index value shifted right by one below it; for every other offset form the carry input has no effect on any output.
- R5: Bit 23 set adds the offset to the base, bit 23 clear subtracts it; arithmetic wraps modulo 2^32.
- R6: With bit 24 set the address is the adjusted base; with bit 24 clear the address is the unmodified base.
- R7: The writeback value is always the adjusted base, in both pre- and post-indexed forms.
- R8: Writeback enable is 1 exactly when (bit 24 is 0 or bit 21 is 1) and the base register index (bits 19:16) is not 15.
- R9: When bits 19:16 equal 15, the base used is the instruction address plus 8, whatever the base register input holds.
- R10: The byte flag output equals bit 22, the load flag output equals bit 20, and the writeback index equals bits 19:16; bits 22 and 20 do not change the address or writeback value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction encoding |
| pc_i | input | 32 | Address of the instruction |
| rn_val_i | input | 32 | Base register value |
| rm_val_i | input | 32 | Index register value |
| carry_i | input | 1 | Current carry flag |
| addr_o | output | 32 | Effective memory address |
| wb_en_o | output | 1 | Base register writeback request |
| wb_data_o | output | 32 | Updated base register value |
| wb_idx_o | output | 4 | Base register index for writeback |
| byte_o | output | 1 | Byte-sized access flag |
| load_o | output | 1 | Load (1) or store (0) flag |

## Verification
The assertions watch, on every input change, that a post-indexed access uses the raw base, that a pre-indexed access lands on the writeback value, that a program-counter base never requests writeback while any other post-indexed base always does, that the constant offset is zero-extended, and that the zero-amount rotate injects the carry. The exact shifted values for each shift kind at amounts 0, 1 and 31, the wrap of subtraction below zero, the program-counter substitution and the absence of any carry or size-bit influence can only be shown by the bench, which compares every output against an independent reference model over directed and random instructions.

// File: rtl/lsag_pkg.sv
package lsag_pkg;

  localparam int INSN_W  = 32;
  localparam int IMM_W   = 12;
  localparam int SHAMT_W = 5;
  localparam int RIDX_W  = 4;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic               reg_off;
    logic               pre;
    logic               up;
    logic               byte_sz;
    logic               wb_req;
    logic               load;
    logic [RIDX_W-1:0]  base_idx;
    logic [SHAMT_W-1:0] sh_amt;
    shift_kind_e        sh_kind;
    logic [IMM_W-1:0]   imm;
  } ldst_fields_t;

  function automatic ldst_fields_t split_insn(input logic [INSN_W-1:0] insn);
    ldst_fields_t f;
    f.reg_off  = insn[25];
    f.pre      = insn[24];
    f.up       = insn[23];
    f.byte_sz  = insn[22];
    f.wb_req   = insn[21];
    f.load     = insn[20];
    f.base_idx = insn[19:16];
    f.sh_amt   = insn[11:7];
    f.sh_kind  = shift_kind_e'(insn[6:5]);
    f.imm      = insn[11:0];
    return f;
  endfunction

endpackage

// File: rtl/lsag_base_sel.sv
module lsag_base_sel #(
  parameter int XLEN     = 32,
  parameter int RIDX_W   = 4,
  parameter int PC_AHEAD = 8
) (
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [XLEN-1:0]   rn_val,
  input  logic [XLEN-1:0]   pc_val,
  output logic [XLEN-1:0]   base_val,
  output logic              base_is_pc
);
  localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'((1 << RIDX_W) - 1);
  localparam logic [XLEN-1:0]   AHEAD  = XLEN'(PC_AHEAD);

  always_comb begin
    base_is_pc = (base_idx == PC_IDX);
    base_val   = base_is_pc ? (pc_val + AHEAD) : rn_val;
  end
endmodule

// File: rtl/lsag_offset_gen.sv
module lsag_offset_gen
  import lsag_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               reg_off,
  input  logic [SHAMT_W-1:0] sh_amt,
  input  shift_kind_e        sh_kind,
  input  logic [IMM_W-1:0]   imm,
  input  logic [XLEN-1:0]    rm_val,
  input  logic               carry_in,
  output logic [XLEN-1:0]    offset
);
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] shifted;

  generate
    if (XLEN > IMM_W) begin : g_zext
      assign imm_ext = {{(XLEN-IMM_W){1'b0}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[XLEN-1:0];
    end
  endgenerate

  function automatic logic [XLEN-1:0] sh_lsl(input logic [XLEN-1:0] x,
                                             input logic [SHAMT_W-1:0] n);
    return x << n;
  endfunction

  function automatic logic [XLEN-1:0] sh_lsr(input logic [XLEN-1:0] x,
                                             input logic [SHAMT_W-1:0] n);
    if (n == '0) return '0;
    return x >> n;
  endfunction

  function automatic logic [XLEN-1:0] sh_asr(input logic [XLEN-1:0] x,
                                             input logic [SHAMT_W-1:0] n);
    if (n == '0) return {XLEN{x[XLEN-1]}};
    return XLEN'($signed(x) >>> n);
  endfunction

  function automatic logic [XLEN-1:0] sh_ror(input logic [XLEN-1:0] x,
                                             input logic [SHAMT_W-1:0] n,
                                             input logic c);
    if (n == '0) return {c, x[XLEN-1:1]};
    return (x >> n) | (x << (XLEN - int'(n)));
  endfunction

  always_comb begin
    unique case (sh_kind)
      SH_LSL:  shifted = sh_lsl(rm_val, sh_amt);
      SH_LSR:  shifted = sh_lsr(rm_val, sh_amt);
      SH_ASR:  shifted = sh_asr(rm_val, sh_amt);
      default: shifted = sh_ror(rm_val, sh_amt, carry_in);
    endcase
    offset = reg_off ? shifted : imm_ext;
  end
endmodule

// File: rtl/lsag_index_unit.sv
module lsag_index_unit #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] offset,
  input  logic            pre,
  input  logic            up,
  input  logic            wb_req,
  input  logic            base_is_pc,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] new_base,
  output logic            wb_en
);
  function automatic logic [XLEN-1:0] step_base(input logic [XLEN-1:0] b,
                                                input logic [XLEN-1:0] o,
                                                input logic add);
    return add ? (b + o) : (b - o);
  endfunction

  always_comb begin
    new_base = step_base(base_val, offset, up);
    mem_addr = pre ? new_base : base_val;
    wb_en    = (!pre || wb_req) && !base_is_pc;
  end
endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
  import lsag_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int PC_AHEAD = 8
) (
  input  logic [INSN_W-1:0] instr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   rn_val_i,
  input  logic [XLEN-1:0]   rm_val_i,
  input  logic              carry_i,
  output logic [XLEN-1:0]   addr_o,
  output logic              wb_en_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic [RIDX_W-1:0] wb_idx_o,
  output logic              byte_o,
  output logic              load_o
);
  ldst_fields_t    fld;
  logic [XLEN-1:0] base_val;
  logic            base_is_pc;
  logic [XLEN-1:0] offset_val;

  assign fld = split_insn(instr_i);

  lsag_base_sel #(
    .XLEN(XLEN), .RIDX_W(RIDX_W), .PC_AHEAD(PC_AHEAD)
  ) u_base (
    .base_idx   (fld.base_idx),
    .rn_val     (rn_val_i),
    .pc_val     (pc_i),
    .base_val   (base_val),
    .base_is_pc (base_is_pc)
  );

  lsag_offset_gen #(.XLEN(XLEN)) u_off (
    .reg_off  (fld.reg_off),
    .sh_amt   (fld.sh_amt),
    .sh_kind  (fld.sh_kind),
    .imm      (fld.imm),
    .rm_val   (rm_val_i),
    .carry_in (carry_i),
    .offset   (offset_val)
  );

  lsag_index_unit #(.XLEN(XLEN)) u_idx (
    .base_val   (base_val),
    .offset     (offset_val),
    .pre        (fld.pre),
    .up         (fld.up),
    .wb_req     (fld.wb_req),
    .base_is_pc (base_is_pc),
    .mem_addr   (addr_o),
    .new_base   (wb_data_o),
    .wb_en      (wb_en_o)
  );

  assign wb_idx_o = fld.base_idx;
  assign byte_o   = fld.byte_sz;
  assign load_o   = fld.load;
endmodule

// File: rtl/ldst_addr_gen_chk.sv
module ldst_addr_gen_chk #(
  parameter int XLEN = 32
) (
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] rn_val_i,
  input logic [XLEN-1:0] rm_val_i,
  input logic            carry_i,
  input logic [XLEN-1:0] addr_o,
  input logic            wb_en_o,
  input logic [XLEN-1:0] wb_data_o,
  input logic [XLEN-1:0] offset_val,
  input logic            base_is_pc
);
  always_comb begin
    assert_post_raw_base_R6: assert (instr_i[24] || instr_i[19:16] == 4'hF || addr_o == rn_val_i)
      else $error("post-indexed address differs from base");
    assert_pre_on_wbval_R7: assert (!instr_i[24] || addr_o == wb_data_o)
      else $error("pre-indexed address differs from writeback value");
    assert_pc_no_wb_R8: assert (!(wb_en_o && base_is_pc))
      else $error("writeback requested for program counter base");
    assert_post_always_wb_R8: assert (instr_i[24] || base_is_pc || wb_en_o)
      else $error("post-indexed access without writeback");
    assert_imm_zext_R1: assert (instr_i[25] || offset_val == XLEN'(instr_i[11:0]))
      else $error("constant offset not zero-extended");
    assert_rrx_carry_R4: assert (!(instr_i[25] && instr_i[6:5] == 2'b11 && instr_i[11:7] == 5'd0)
                                 || (offset_val[XLEN-1] == carry_i
                                     && offset_val[XLEN-2:0] == rm_val_i[XLEN-1:1]))
      else $error("zero-amount rotate does not inject carry");
  end
endmodule

bind ldst_addr_gen ldst_addr_gen_chk #(.XLEN(XLEN)) u_chk (
  .instr_i    (instr_i),
  .rn_val_i   (rn_val_i),
  .rm_val_i   (rm_val_i),
  .carry_i    (carry_i),
  .addr_o     (addr_o),
  .wb_en_o    (wb_en_o),
  .wb_data_o  (wb_data_o),
  .offset_val (offset_val),
  .base_is_pc (base_is_pc)
);

// File: tb/tb_ldst_addr_gen.sv
module tb_ldst_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0, pc = '0, rn = '0, rm = '0;
  logic        carry = 1'b0;
  logic [31:0] addr, wbd;
  logic        wben, byt, ld;
  logic [3:0]  wbi;
  int          errors = 0;
  int          checks = 0;
  int          cycles = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  ldst_addr_gen dut (
    .instr_i(instr), .pc_i(pc), .rn_val_i(rn), .rm_val_i(rm), .carry_i(carry),
    .addr_o(addr), .wb_en_o(wben), .wb_data_o(wbd), .wb_idx_o(wbi),
    .byte_o(byt), .load_o(ld)
  );

  // Reference: wide integer arithmetic, masked back to 32 bits.
  task automatic model(input logic [31:0] ins, input logic [31:0] pcv,
                       input logic [31:0] rnv, input logic [31:0] rmv,
                       input logic c, output logic [31:0] e_addr,
                       output logic [31:0] e_wb, output logic e_wen);
    longint unsigned mask, base, off, upd;
    int n;
    mask = 64'hFFFF_FFFF;
    base = (ins[19:16] == 4'hF) ? ((longint'(pcv) + 8) & mask) : longint'(rnv);
    if (!ins[25]) off = longint'(ins[11:0]);
    else begin
      n = int'(ins[11:7]);
      case (ins[6:5])
        2'b00: off = (longint'(rmv) << n) & mask;
        2'b01: off = (n == 0) ? 0 : (longint'(rmv) >> n);
        2'b10: begin
          if (n == 0) n = 32;
          off = ({{32{rmv[31]}}, rmv} >> n) & mask;
        end
        default: begin
          if (n == 0) off = (longint'(c) << 31) | (longint'(rmv) >> 1);
          else off = ({rmv, rmv} >> n) & mask;
        end
      endcase
    end
    if (ins[23]) upd = (base + off) & mask;
    else upd = (base + 64'h1_0000_0000 - off) & mask;
    e_wb   = upd[31:0];
    e_addr = ins[24] ? upd[31:0] : base[31:0];
    e_wen  = (!ins[24] || ins[21]) && (ins[19:16] != 4'hF);
  endtask

  function automatic logic [31:0] mk_imm(bit p, bit u, bit w, logic [3:0] b, logic [11:0] imm);
    return {4'hE, 2'b01, 1'b0, p, u, 1'b0, w, 1'b0, b, 4'h1, imm};
  endfunction

  function automatic logic [31:0] mk_reg(bit p, bit u, bit w, logic [3:0] b,
                                         logic [4:0] amt, logic [1:0] kind);
    return {4'hE, 2'b01, 1'b1, p, u, 1'b0, w, 1'b0, b, 4'h1, amt, kind, 1'b0, 4'h2};
  endfunction

  task automatic cmp32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // Drive after a rising edge, compare at the following falling edge.
  task automatic apply(string tag, logic [31:0] ins, logic [31:0] pcv,
                       logic [31:0] rnv, logic [31:0] rmv, logic c);
    logic [31:0] ea, ew;
    logic ee;
    @(posedge clk);
    instr = ins; pc = pcv; rn = rnv; rm = rmv; carry = c;
    @(negedge clk);
    model(ins, pcv, rnv, rmv, c, ea, ew, ee);
    cmp32(tag, "addr", addr, ea);
    cmp32(tag, "wb_data", wbd, ew);
    cmp32(tag, "wb_en", {31'b0, wben}, {31'b0, ee});
    cmp32({tag, " R10"}, "wb_idx", {28'b0, wbi}, {28'b0, ins[19:16]});
    cmp32({tag, " R10"}, "byte", {31'b0, byt}, {31'b0, ins[22]});
    cmp32({tag, " R10"}, "load", {31'b0, ld}, {31'b0, ins[20]});
  endtask

  task automatic expect_val(string tag, string what, logic [31:0] act, logic [31:0] exp);
    cmp32(tag, what, act, exp);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: all-zero word is a post-indexed store with base 0
    expect_val("R6 reset", "addr", addr, 32'h0);
    expect_val("R8 reset", "wb_en", {31'b0, wben}, 32'h1);

    apply("R1 R5 pre add", mk_imm(1, 1, 0, 4'd3, 12'hFFF), 0, 32'h1000, 0, 0);
    expect_val("R1", "addr", addr, 32'h1FFF);
    expect_val("R8 pre noW", "wb_en", {31'b0, wben}, 32'h0);
    apply("R5 R8 pre sub W", mk_imm(1, 0, 1, 4'd3, 12'h010), 0, 32'h1000, 0, 0);
    expect_val("R5", "addr", addr, 32'h0FF0);
    apply("R5 wrap", mk_imm(1, 0, 1, 4'd4, 12'h008), 0, 32'h4, 0, 0);
    expect_val("R5 wrap", "addr", addr, 32'hFFFF_FFFC);
    apply("R6 R7 post add", mk_imm(0, 1, 0, 4'd5, 12'h024), 0, 32'h2000, 0, 0);
    expect_val("R7", "wb_data", wbd, 32'h2024);
    expect_val("R6", "addr", addr, 32'h2000);
    apply("R2 lsl3", mk_reg(1, 1, 0, 4'd1, 5'd3, 2'b00), 0, 32'h100, 32'h11, 0);
    expect_val("R2", "addr", addr, 32'h188);
    apply("R2 lsr1", mk_reg(1, 1, 0, 4'd1, 5'd1, 2'b01), 0, 0, 32'h8000_0002, 0);
    apply("R2 asr31", mk_reg(1, 1, 0, 4'd1, 5'd31, 2'b10), 0, 0, 32'h8000_0000, 0);
    apply("R2 ror4", mk_reg(1, 1, 0, 4'd1, 5'd4, 2'b11), 0, 0, 32'h0000_00AB, 0);
    expect_val("R2 ror4", "addr", addr, 32'hB000_000A);
    apply("R3 lsr0", mk_reg(1, 1, 0, 4'd1, 5'd0, 2'b01), 0, 32'h50, 32'hFFFF_FFFF, 0);
    expect_val("R3 lsr0", "addr", addr, 32'h50);
    apply("R3 asr0 neg", mk_reg(1, 1, 0, 4'd1, 5'd0, 2'b10), 0, 32'h50, 32'h8000_0000, 0);
    expect_val("R3 asr0", "addr", addr, 32'h4F);
    apply("R3 asr0 pos", mk_reg(1, 0, 0, 4'd1, 5'd0, 2'b10), 0, 32'h50, 32'h7FFF_FFFF, 0);
    apply("R4 rrx c1", mk_reg(1, 1, 0, 4'd1, 5'd0, 2'b11), 0, 0, 32'h0000_0003, 1);
    expect_val("R4 rrx", "addr", addr, 32'h8000_0001);
    apply("R4 rrx c0", mk_reg(1, 1, 0, 4'd1, 5'd0, 2'b11), 0, 0, 32'h0000_0003, 0);
    apply("R4 lsl c1", mk_reg(1, 1, 0, 4'd1, 5'd2, 2'b00), 0, 0, 32'h5, 1);
    expect_val("R4 carry ignored", "addr", addr, 32'h14);
    apply("R4 imm c1", mk_imm(1, 1, 0, 4'd1, 12'h7), 0, 32'h10, 0, 1);
    expect_val("R4 carry ignored", "addr", addr, 32'h17);
    apply("R2 bit4", mk_reg(1, 1, 0, 4'd1, 5'd2, 2'b00) | 32'h10, 0, 0, 32'h5, 0);
    expect_val("R2 bit4 ignored", "addr", addr, 32'h14);
    apply("R9 R8 pc pre W", mk_imm(1, 1, 1, 4'hF, 12'h4), 32'h8000, 32'hDEAD_BEEF, 0, 0);
    expect_val("R9", "addr", addr, 32'h800C);
    expect_val("R8 pc", "wb_en", {31'b0, wben}, 32'h0);
    apply("R9 pc post", mk_imm(0, 0, 0, 4'hF, 12'h4), 32'h8000, 32'h1, 0, 0);
    expect_val("R9 post", "addr", addr, 32'h8008);
    apply("R10 byte load", mk_imm(1, 1, 0, 4'd2, 12'h3) | 32'h0050_0000, 0, 32'h40, 0, 0);
    expect_val("R10 size bits ignored", "addr", addr, 32'h43);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ins;
      ins = $urandom;
      ins[27:26] = 2'b01;
      if (i % 7 == 0) ins[19:16] = 4'hF;
      apply("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random", ins, $urandom, $urandom, $urandom,
            1'($urandom));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule